// File: doc/BRIEF.md
# Watermark Byte FIFO

This block is a small synchronous first-in first-out buffer that sits between a register bus and a serial shift engine. Both sides run on one clock. Each side also has its own clock-enable qualifier, so the bus side can advance at full clock rate while the serial side advances only on its bit-strobe cycles. It holds eight entries of eight bits by default.

Data enters through a valid/ready pair and leaves through a second valid/ready pair. A beat is taken on the input only on a cycle where the write clock-enable is high, `in_valid` is high and `in_ready` is high. `in_ready` low means the buffer is full, and an offered byte is then dropped. A beat leaves on the output only on a cycle where the read clock-enable is high, `out_ready` is high and `out_valid` is high. `out_valid` low means the buffer is empty. `out_data` always shows the oldest stored byte, with no register stage on the read path.

Two level-sensitive flags compare the current fill level against a programmable threshold. They are meant to drive a transmit-side and a receive-side interrupt.

Top module: `wm_fifo`

## Requirements
- R1: After a cycle with `rst_n` low at a rising edge, the buffer is empty: `out_valid` is 0, `in_ready` is 1 and `rx_high` is 0.
- R2: A byte is stored only at an edge where `wr_ce`, `in_valid` and `in_ready` are all 1. With `wr_ce` at 0 or `in_valid` at 0, the fill level and contents stay unchanged.
- R3: The oldest entry is removed only at an edge where `rd_ce`, `out_ready` and `out_valid` are all 1. With `rd_ce` at 0, the head byte and the fill level stay unchanged.
- R4: Bytes leave in the order they were accepted. `out_data` shows the oldest entry while `out_valid` is 1, and it holds steady until that entry is removed.
- R5: After 8 stored entries, `in_ready` is 0. A byte offered while full is dropped and never appears on `out_data`.
- R6: A read request while empty (`out_valid` = 0) has no effect: a later write is the next byte seen, and the fill level becomes one.
- R7: `tx_low` is 1 exactly while the fill level is strictly less than `level_thr` (a 3-bit unsigned value).
- R8: `rx_high` is 1 exactly while the fill level is strictly greater than `level_thr`.
- R9: Both flags are plain levels. They drop in the cycle after the fill level stops meeting their comparison; nothing holds them.
- R10: A write and a read accepted at the same edge leave the fill level unchanged and preserve order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset of both pointers |
| wr_ce | input | 1 | Write-side clock-enable qualifier |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Buffer not full |
| in_data | input | 8 | Input byte |
| rd_ce | input | 1 | Read-side clock-enable qualifier |
| out_valid | output | 1 | Buffer not empty |
| out_ready | input | 1 | Consumer takes the head byte |
| out_data | output | 8 | Oldest stored byte |
| level_thr | input | 3 | Watermark threshold |
| tx_low | output | 1 | Fill level below threshold |
| rx_high | output | 1 | Fill level above threshold |

## Verification
A wrong pointer shows up at the ports within one clock. `in_ready`, `out_valid` and both watermark flags all derive from the pointer difference. So a missed or extra increment shifts the flag pattern at the very next edge, and the bench sweeps the threshold across the fill level to expose that. A wrong read pointer or storage slot instead appears as a byte out of order on `out_data`. This stays invisible until that entry reaches the head, so the bench drains every fill completely and compares each byte.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_DEPTH  = 8;
endpackage

// File: rtl/wmf_ptr.sv
module wmf_ptr #(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [AW:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && waddr == AW'(i)) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/wmf_level.sv
module wmf_level #(
  parameter int AW = 3
) (
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  input  logic [AW-1:0] thr,
  output logic          full,
  output logic          empty,
  output logic          below,
  output logic          above
);
  logic [AW:0] fill;
  logic [AW:0] thr_x;

  assign fill  = wr_ptr - rd_ptr;
  assign thr_x = {1'b0, thr};
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign below = (fill < thr_x);
  assign above = (fill > thr_x);
endmodule

// File: rtl/wm_fifo.sv
module wm_fifo
  import wmf_pkg::*;
#(
  parameter int DW    = DEF_DATA_W,
  parameter int DEPTH = DEF_DEPTH,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ce,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          rd_ce,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic [AW-1:0] level_thr,
  output logic          tx_low,
  output logic          rx_high
);
  logic [AW:0] wr_ptr, rd_ptr;
  logic        full, empty, wr_take, rd_take;

  assign wr_take   = wr_ce && in_valid && !full;
  assign rd_take   = rd_ce && out_ready && !empty;
  assign in_ready  = !full;
  assign out_valid = !empty;

  wmf_ptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .step(wr_take), .ptr(wr_ptr));

  wmf_ptr #(.AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .step(rd_take), .ptr(rd_ptr));

  wmf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_take), .waddr(wr_ptr[AW-1:0]), .wdata(in_data),
    .raddr(rd_ptr[AW-1:0]), .rdata(out_data));

  wmf_level #(.AW(AW)) u_level (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .thr(level_thr),
    .full(full), .empty(empty), .below(tx_low), .above(rx_high));
endmodule

// File: rtl/wm_fifo_chk.sv
module wm_fifo_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ce,
  input logic          in_valid,
  input logic          in_ready,
  input logic          rd_ce,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [AW-1:0] level_thr,
  input logic          tx_low,
  input logic          rx_high
);
  logic [AW:0] occ;
  logic        w_acc, r_acc;

  assign w_acc = wr_ce && in_valid && in_ready;
  assign r_acc = rd_ce && out_ready && out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + (AW+1)'(w_acc) - (AW+1)'(r_acc);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) occ <= (AW+1)'(DEPTH)); // R5
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n) in_ready == (occ != (AW+1)'(DEPTH))); // R5
  AST_VALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == (occ != '0)); // R6
  AST_TX_LOW: assert property (@(posedge clk) disable iff (!rst_n) tx_low == (occ < {1'b0, level_thr})); // R7
  AST_RX_HIGH: assert property (@(posedge clk) disable iff (!rst_n) rx_high == (occ > {1'b0, level_thr})); // R8
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !r_acc) |=> $stable(out_data)); // R4
  AST_STALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!rd_ce && !w_acc) |=> $stable(out_valid)); // R3
endmodule

bind wm_fifo wm_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .in_valid(in_valid),
  .in_ready(in_ready), .rd_ce(rd_ce), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .level_thr(level_thr),
  .tx_low(tx_low), .rx_high(rx_high));

// File: tb/sim_wm_fifo.sv
module sim_wm_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ce = 0, in_valid = 0, rd_ce = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic [2:0] level_thr = 3;
  logic       in_ready, out_valid, tx_low, rx_high;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  int occ = 0, head = 0, tail = 0;
  logic [7:0] q [64];

  always #5 clk = ~clk;

  wm_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .rd_ce(rd_ce),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level_thr(level_thr), .tx_low(tx_low), .rx_high(rx_high));

  typedef struct packed {
    logic       wce;
    logic       wv;
    logic [7:0] d;
    logic       rce;
    logic       rr;
    logic [2:0] thr;
    logic [3:0] occ;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 3'd3, 4'd1},  // R2 write
    '{1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 3'd3, 4'd1},  // R2 ce low: ignored
    '{1'b1, 1'b1, 8'h22, 1'b0, 1'b0, 3'd3, 4'd2},
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'd3, 4'd2},  // R3 rd_ce low
    '{1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 3'd3, 4'd3},
    '{1'b1, 1'b1, 8'h44, 1'b0, 1'b0, 3'd3, 4'd4},  // R8 above
    '{1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 3'd3, 4'd4},  // R10
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3, 4'd3},  // R9 rx_high drops
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3, 4'd2},  // R7 below
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3, 4'd1},
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3, 4'd0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3, 4'd0},  // R6 empty read
    '{1'b1, 1'b1, 8'h66, 1'b0, 1'b0, 3'd0, 4'd1}   // R6 next byte
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic wce, input logic wv, input logic [7:0] d,
                      input logic rce, input logic rr, input logic [2:0] thr);
    bit wa, ra;
    @(negedge clk);
    wr_ce = wce; in_valid = wv; in_data = d; rd_ce = rce; out_ready = rr; level_thr = thr;
    wa = wce && wv && (occ < 8);
    ra = rce && rr && (occ > 0);
    @(posedge clk);
    if (ra) begin head++; occ--; end
    if (wa) begin q[tail % 64] = d; tail++; occ++; end
    #2;
  endtask

  task automatic flags(input string req);
    chk({req, " in_ready"},  32'(in_ready),  32'(occ != 8));
    chk({req, " out_valid"}, 32'(out_valid), 32'(occ != 0));
    chk({req, " tx_low"},    32'(tx_low),    32'(occ < int'(level_thr)));
    chk({req, " rx_high"},   32'(rx_high),   32'(occ > int'(level_thr)));
    if (occ > 0) chk({req, " out_data"}, 32'(out_data), 32'(q[head % 64]));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_ready",  32'(in_ready),  1);
    chk("R1 rx_high",   32'(rx_high),   0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wce, VEC[i].wv, VEC[i].d, VEC[i].rce, VEC[i].rr, VEC[i].thr);
      chk("R2/R3 table fill", 32'(occ), 32'(VEC[i].occ));
      flags("R4/R7/R8 table");
    end

    // drain, then fill to full with threshold 7 (R5)
    step(0, 0, 0, 1, 1, 3'd7);
    for (int i = 0; i < 8; i++) step(1, 1, 8'(8'hA0 + i), 0, 0, 3'd7);
    chk("R5 in_ready full", 32'(in_ready), 0);
    flags("R5 full");
    step(1, 1, 8'hEE, 0, 0, 3'd7);  // dropped
    flags("R5 drop");
    for (int i = 0; i < 8; i++) begin
      chk("R5 drain order", 32'(out_data), 32'(8'hA0 + i));
      step(0, 0, 0, 1, 1, 3'd7);
    end
    chk("R5 empty after drain", 32'(out_valid), 0);

    // threshold 0 while empty (R7)
    step(0, 0, 0, 0, 0, 3'd0);
    chk("R7 thr0 empty", 32'(tx_low), 0);
    flags("R7 thr0");

    // reset mid-operation (R1)
    step(1, 1, 8'h5A, 0, 0, 3'd2);
    step(1, 1, 8'h5B, 0, 0, 3'd2);
    @(negedge clk); rst_n = 1'b0; wr_ce = 0; in_valid = 0;
    @(posedge clk); #2;
    chk("R1 reset empty", 32'(out_valid), 0);
    chk("R1 reset ready", 32'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    occ = 0; head = tail;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule